// File: doc/BRIEF.md
# Condition-Code Branch and Flag Unit

This unit keeps the status flags of a small 8-bit accumulator processor: negative (N), zero (Z), overflow (V), carry (C) and the interrupt mask (I). When a strobe accompanies an operation, the unit recomputes the flags. It handles compares of either accumulator against a memory operand, the accumulator-to-accumulator compare, bit tests, clears, and the three single-flag clear operations.

For the sixteen relative branches, the unit evaluates the branch condition from the flags as they stand. It reports whether the branch is taken and produces the next program counter. It also reports how many cycles the operation takes.

The surrounding sequencer supplies the operation class, the low nibble of the branch opcode, both accumulators, the memory operand, the signed displacement and the current PC. All results appear registered on the clock edge that accepts the strobe. A one-cycle completion pulse marks them.

Top module: `ccu_top`

## Requirements
- R1: While reset is asserted and after it is released, N, Z, V and C read 0, I reads 1, br_taken is 0, next_pc is 0, op_cycles is 0 and done is 0.
- R2: In a cycle without op_valid, flags, br_taken, next_pc and op_cycles keep their values. A strobed op_sel code from 10 to 15 leaves all five flags unchanged.
- R3: op_sel encoding: 0 compares A with M, 1 compares B with M, 2 compares A with B. A compare sets N and Z from the 8-bit difference and sets V and C as in R4. It leaves I unchanged and stores no result.
- R4: For a compare, C is 1 exactly when the minuend is below the subtrahend as unsigned numbers. V is 1 exactly when the true signed difference lies outside -128..127.
- R5: op_sel 3 tests A AND M and op_sel 4 tests B AND M. Each sets N from bit 7 and Z from a zero result, clears V, and leaves C and I unchanged.
- R6: op_sel 5 (clear) sets N=0, Z=1, V=0, C=0 and leaves I unchanged.
- R7: op_sel 6 clears only C, op_sel 7 clears only I, and op_sel 8 clears only V.
- R8: op_sel 9 is a relative branch whose condition is selected by br_cond, the low opcode nibble. The conditions are:
  - 0: always; 1: never
  - 2: C=0 and Z=0; 3: C=1 or Z=1
  - 4: C=0; 5: C=1
  - 6: Z=0; 7: Z=1
  - 8: V=0; 9: V=1
  - A: N=0; B: N=1
  - C: N equals V; D: N differs from V
  - E: Z=0 and N equals V; F: Z=1 or N differs from V
- R9: After a branch, next_pc equals pc+2 plus the sign-extended rel_off when the branch is taken, and pc+2 otherwise, both modulo 2^16.
- R10: A branch leaves all flags unchanged and reports op_cycles=3 whether or not it is taken. Every other strobed operation reports op_cycles=2.
- R11: done is high in exactly the cycle after each strobe. br_taken is set only by a taken branch and is cleared by any other strobed operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_sel | input | 4 | Operation class (see R3, R5 to R8) |
| br_cond | input | 4 | Branch condition code (low opcode nibble) |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| mem_opd | input | 8 | Memory operand |
| rel_off | input | 8 | Signed branch displacement |
| pc | input | 16 | Address of the branch instruction |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry/borrow flag |
| flag_i | output | 1 | Interrupt mask |
| br_taken | output | 1 | Last branch was taken |
| next_pc | output | 16 | Program counter after the last branch |
| op_cycles | output | 4 | Cycle count of the last operation |
| done | output | 1 | Result-valid pulse |

## Verification
The assertions assume that op_sel, br_cond, the operands and pc carry known values whenever op_valid is high. They also assume that the width relation keeps the PC wider than the displacement. Their timing-based checks rely on inputs being sampled only on the accepting edge. The stimulus therefore changes inputs only on the falling edge and holds them for a full cycle. It draws op_sel from all sixteen codes, so the unused codes 10 to 15 are exercised, and it never leaves a strobed input undriven.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

  typedef enum logic [3:0] {
    OP_CMPA = 4'd0,
    OP_CMPB = 4'd1,
    OP_CBA  = 4'd2,
    OP_BITA = 4'd3,
    OP_BITB = 4'd4,
    OP_CLR  = 4'd5,
    OP_CLC  = 4'd6,
    OP_CLI  = 4'd7,
    OP_CLV  = 4'd8,
    OP_BRA  = 4'd9
  } ccu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

  localparam ccr_t CCR_RESET   = '{n: 1'b0, z: 1'b0, v: 1'b0, c: 1'b0};
  localparam ccr_t CCR_CLEARED = '{n: 1'b0, z: 1'b1, v: 1'b0, c: 1'b0};

  // Branch condition decode: code is the low nibble of the branch opcode.
  function automatic logic cond_met(input logic [3:0] code, input ccr_t f);
    logic lt;
    lt = f.n ^ f.v;
    case (code)
      4'h0:    return 1'b1;
      4'h1:    return 1'b0;
      4'h2:    return ~(f.c | f.z);
      4'h3:    return f.c | f.z;
      4'h4:    return ~f.c;
      4'h5:    return f.c;
      4'h6:    return ~f.z;
      4'h7:    return f.z;
      4'h8:    return ~f.v;
      4'h9:    return f.v;
      4'hA:    return ~f.n;
      4'hB:    return f.n;
      4'hC:    return ~lt;
      4'hD:    return lt;
      4'hE:    return ~(f.z | lt);
      default: return f.z | lt;
    endcase
  endfunction

endpackage

// File: rtl/ccu_alu.sv
module ccu_alu
  import ccu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] lhs,
  input  logic [DW-1:0] rhs,
  output ccr_t          sub_f,
  output logic          and_n,
  output logic          and_z
);

  localparam int MSB = DW - 1;

  function automatic ccr_t sub_flags(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW:0] wide;
    ccr_t f;
    wide = {1'b0, a} - {1'b0, b};
    f.n  = wide[MSB];
    f.z  = (wide[MSB:0] == '0);
    f.c  = wide[DW];
    f.v  = (a[MSB] ^ b[MSB]) & (a[MSB] ^ wide[MSB]);
    return f;
  endfunction

  logic [DW-1:0] masked;

  assign sub_f  = sub_flags(lhs, rhs);
  assign masked = lhs & rhs;
  assign and_n  = masked[MSB];
  assign and_z  = (masked == '0);

endmodule

// File: rtl/ccu_branch.sv
module ccu_branch
  import ccu_pkg::*;
#(
  parameter int DW   = 8,
  parameter int PW   = 16,
  parameter int STEP = 2
) (
  input  logic [3:0]    br_cond,
  input  ccr_t          cur_f,
  input  logic [PW-1:0] pc,
  input  logic [DW-1:0] rel_off,
  output logic          cond_true,
  output logic [PW-1:0] seq_pc,
  output logic [PW-1:0] tgt_pc,
  output logic [PW-1:0] pick_pc
);

  localparam int EXT = PW - DW;

  function automatic logic [PW-1:0] rel_target(input logic [PW-1:0] base,
                                               input logic [DW-1:0] d);
    return base + {{EXT{d[DW-1]}}, d};
  endfunction

  assign cond_true = cond_met(br_cond, cur_f);
  assign seq_pc    = pc + PW'(STEP);
  assign tgt_pc    = rel_target(seq_pc, rel_off);
  assign pick_pc   = cond_true ? tgt_pc : seq_pc;

endmodule

// File: rtl/ccu_flagreg.sv
module ccu_flagreg
  import ccu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic upd_en,
  input  ccr_t d_f,
  input  logic d_i,
  output ccr_t q_f,
  output logic q_i
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_f <= CCR_RESET;
      q_i <= 1'b1;
    end else if (upd_en) begin
      q_f <= d_f;
      q_i <= d_i;
    end
  end

endmodule

// File: rtl/ccu_top.sv
module ccu_top
  import ccu_pkg::*;
#(
  parameter int DW       = 8,
  parameter int PW       = 16,
  parameter int CW       = 4,
  parameter int STEP     = 2,
  parameter int BR_CYC   = 3,
  parameter int BASE_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [3:0]    op_sel,
  input  logic [3:0]    br_cond,
  input  logic [DW-1:0] acc_a,
  input  logic [DW-1:0] acc_b,
  input  logic [DW-1:0] mem_opd,
  input  logic [DW-1:0] rel_off,
  input  logic [PW-1:0] pc,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_v,
  output logic          flag_c,
  output logic          flag_i,
  output logic          br_taken,
  output logic [PW-1:0] next_pc,
  output logic [CW-1:0] op_cycles,
  output logic          done
);

  ccu_op_e       op;
  ccr_t          cur_f, sub_f, nxt_f;
  logic          cur_i, nxt_i;
  logic          and_n, and_z;
  logic [DW-1:0] lhs, rhs;
  logic          is_bra, upd_en, cond_true;
  logic [PW-1:0] seq_pc, tgt_pc, pick_pc;

  assign op     = ccu_op_e'(op_sel);
  assign is_bra = (op == OP_BRA);
  assign upd_en = op_valid;

  // operand routing
  always_comb begin
    lhs = acc_a;
    rhs = mem_opd;
    case (op)
      OP_CMPB, OP_BITB: lhs = acc_b;
      OP_CBA:           rhs = acc_b;
      default:          ;
    endcase
  end

  ccu_alu #(.DW(DW)) u_alu (
    .lhs   (lhs),
    .rhs   (rhs),
    .sub_f (sub_f),
    .and_n (and_n),
    .and_z (and_z)
  );

  ccu_branch #(.DW(DW), .PW(PW), .STEP(STEP)) u_br (
    .br_cond   (br_cond),
    .cur_f     (cur_f),
    .pc        (pc),
    .rel_off   (rel_off),
    .cond_true (cond_true),
    .seq_pc    (seq_pc),
    .tgt_pc    (tgt_pc),
    .pick_pc   (pick_pc)
  );

  // next flag values per operation
  always_comb begin
    nxt_f = cur_f;
    nxt_i = cur_i;
    case (op)
      OP_CMPA, OP_CMPB, OP_CBA: nxt_f = sub_f;
      OP_BITA, OP_BITB: begin
        nxt_f.n = and_n;
        nxt_f.z = and_z;
        nxt_f.v = 1'b0;
      end
      OP_CLR:  nxt_f   = CCR_CLEARED;
      OP_CLC:  nxt_f.c = 1'b0;
      OP_CLI:  nxt_i   = 1'b0;
      OP_CLV:  nxt_f.v = 1'b0;
      default: ;
    endcase
  end

  ccu_flagreg u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_en (upd_en),
    .d_f    (nxt_f),
    .d_i    (nxt_i),
    .q_f    (cur_f),
    .q_i    (cur_i)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      br_taken  <= 1'b0;
      next_pc   <= '0;
      op_cycles <= '0;
      done      <= 1'b0;
    end else begin
      done <= op_valid;
      if (op_valid) begin
        op_cycles <= is_bra ? CW'(BR_CYC) : CW'(BASE_CYC);
        br_taken  <= is_bra & cond_true;
        if (is_bra) next_pc <= pick_pc;
      end
    end
  end

  assign flag_n = cur_f.n;
  assign flag_z = cur_f.z;
  assign flag_v = cur_f.v;
  assign flag_c = cur_f.c;
  assign flag_i = cur_i;

endmodule

// File: rtl/ccu_chk.sv
module ccu_chk
  import ccu_pkg::*;
#(
  parameter int DW = 8,
  parameter int PW = 16,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [3:0]    op_sel,
  input logic [3:0]    br_cond,
  input logic [DW-1:0] acc_a,
  input logic [DW-1:0] mem_opd,
  input logic          flag_n,
  input logic          flag_z,
  input logic          flag_v,
  input logic          flag_c,
  input logic          flag_i,
  input logic          br_taken,
  input logic [PW-1:0] next_pc,
  input logic [CW-1:0] op_cycles,
  input logic          done,
  input logic [PW-1:0] seq_pc,
  input logic [PW-1:0] tgt_pc
);

  logic [4:0] all_f;
  assign all_f = {flag_n, flag_z, flag_v, flag_c, flag_i};

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(all_f) && $stable(next_pc) && $stable(br_taken) && $stable(op_cycles));

  // R3
  cmp_keeps_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel <= 4'd2) |=> $stable(flag_i));

  // R4
  cmp_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OP_CMPA) |=> flag_c == $past(acc_a < mem_opd));

  // R5
  bit_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_sel == OP_BITA || op_sel == OP_BITB)) |=> !flag_v && $stable(flag_c) && $stable(flag_i));

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OP_CLR) |=> !flag_n && flag_z && !flag_v && !flag_c && $stable(flag_i));

  // R7
  clc_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OP_CLC) |=> !flag_c && $stable({flag_n, flag_z, flag_v, flag_i}));

  // R7
  cli_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OP_CLI) |=> !flag_i && $stable({flag_n, flag_z, flag_v, flag_c}));

  // R7
  clv_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OP_CLV) |=> !flag_v && $stable({flag_n, flag_z, flag_c, flag_i}));

  // R8
  bra_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OP_BRA && br_cond == 4'h0) |=> br_taken);

  // R8
  bra_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OP_BRA && br_cond == 4'h1) |=> !br_taken);

  // R9
  bra_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OP_BRA) |=> next_pc == (br_taken ? $past(tgt_pc) : $past(seq_pc)));

  // R10
  bra_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OP_BRA) |=> $stable(all_f) && op_cycles == CW'(3));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> done);

  // R11
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !done);

  // R11
  taken_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel != OP_BRA) |=> !br_taken);

endmodule

bind ccu_top ccu_chk #(.DW(DW), .PW(PW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_sel    (op_sel),
  .br_cond   (br_cond),
  .acc_a     (acc_a),
  .mem_opd   (mem_opd),
  .flag_n    (flag_n),
  .flag_z    (flag_z),
  .flag_v    (flag_v),
  .flag_c    (flag_c),
  .flag_i    (flag_i),
  .br_taken  (br_taken),
  .next_pc   (next_pc),
  .op_cycles (op_cycles),
  .done      (done),
  .seq_pc    (seq_pc),
  .tgt_pc    (tgt_pc)
);

// File: tb/sim_ccu_top.sv
`timescale 1ns/1ps
module sim_ccu_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_sel = '0, br_cond = '0;
  logic [7:0]  acc_a = '0, acc_b = '0, mem_opd = '0, rel_off = '0;
  logic [15:0] pc = '0;
  logic        flag_n, flag_z, flag_v, flag_c, flag_i, br_taken, done;
  logic [15:0] next_pc;
  logic [3:0]  op_cycles;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference state
  int mn, mz, mv, mc, mi, mtk, mpc, mcyc, mdone;

  always #2 clk = ~clk;

  ccu_top u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel), .br_cond(br_cond),
    .acc_a(acc_a), .acc_b(acc_b), .mem_opd(mem_opd), .rel_off(rel_off), .pc(pc),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c), .flag_i(flag_i),
    .br_taken(br_taken), .next_pc(next_pc), .op_cycles(op_cycles), .done(done)
  );

  task automatic model_reset();
    mn = 0; mz = 0; mv = 0; mc = 0; mi = 1; mtk = 0; mpc = 0; mcyc = 0; mdone = 0;
  endtask

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    int ef, af;
    ef = (mn << 4) | (mz << 3) | (mv << 2) | (mc << 1) | mi;
    af = int'({flag_n, flag_z, flag_v, flag_c, flag_i});
    check(af == ef, tag, "flags NZVCI", af, ef);
    check(int'(br_taken) == mtk, "R8", "br_taken", int'(br_taken), mtk);
    check(int'(next_pc) == mpc, "R9", "next_pc", int'(next_pc), mpc);
    check(int'(op_cycles) == mcyc, "R10", "op_cycles", int'(op_cycles), mcyc);
    check(int'(done) == mdone, "R11", "done", int'(done), mdone);
  endtask

  // signed-range view of a subtraction
  task automatic model_sub(input int x, input int y);
    int sx, sy, d, r;
    sx = (x >= 128) ? x - 256 : x;
    sy = (y >= 128) ? y - 256 : y;
    d  = sx - sy;
    r  = (x - y + 256) % 256;
    mn = (r >= 128) ? 1 : 0;
    mz = (r == 0) ? 1 : 0;
    mv = (d < -128 || d > 127) ? 1 : 0;
    mc = (x < y) ? 1 : 0;
  endtask

  function automatic int model_take(input int code);
    case (code)
      0:  return 1;
      1:  return 0;
      2:  return (mc == 0 && mz == 0) ? 1 : 0;
      3:  return (mc == 1 || mz == 1) ? 1 : 0;
      4:  return (mc == 0) ? 1 : 0;
      5:  return mc;
      6:  return (mz == 0) ? 1 : 0;
      7:  return mz;
      8:  return (mv == 0) ? 1 : 0;
      9:  return mv;
      10: return (mn == 0) ? 1 : 0;
      11: return mn;
      12: return (mn == mv) ? 1 : 0;
      13: return (mn != mv) ? 1 : 0;
      14: return (mz == 0 && mn == mv) ? 1 : 0;
      default: return (mz == 1 || mn != mv) ? 1 : 0;
    endcase
  endfunction

  task automatic step(input bit v, input int op, input int cnd, input int a, input int b,
                      input int m, input int d, input int p, input string tag);
    int sd, r;
    @(negedge clk);
    op_valid = v; op_sel = op[3:0]; br_cond = cnd[3:0];
    acc_a = a[7:0]; acc_b = b[7:0]; mem_opd = m[7:0]; rel_off = d[7:0]; pc = p[15:0];
    if (v) begin
      mdone = 1;
      mcyc  = (op == 9) ? 3 : 2;
      mtk   = 0;
      case (op)
        0: model_sub(a, m);
        1: model_sub(b, m);
        2: model_sub(a, b);
        3, 4: begin
          r  = ((op == 3) ? a : b) & m;
          mn = (r >= 128) ? 1 : 0;
          mz = (r == 0) ? 1 : 0;
          mv = 0;
        end
        5: begin mn = 0; mz = 1; mv = 0; mc = 0; end
        6: mc = 0;
        7: mi = 0;
        8: mv = 0;
        9: begin
          sd  = (d >= 128) ? d - 256 : d;
          mtk = model_take(cnd);
          mpc = mtk ? (p + 2 + sd + 65536) % 65536 : (p + 2) % 65536;
        end
        default: ;
      endcase
    end else begin
      mdone = 0;
    end
    @(posedge clk);
    #1;
    compare_all(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; op_valid = 0;
    model_reset();
    @(posedge clk); #1;
    compare_all("R1");
    @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    compare_all("R1");
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (2) @(posedge clk);
    do_reset();

    // R2 idle and unused codes
    step(0, 0, 0, 8'h10, 0, 8'h20, 0, 0, "R2");
    step(1, 12, 0, 8'h00, 0, 8'h00, 0, 0, "R2");
    step(1, 15, 0, 8'h00, 0, 8'h01, 0, 0, "R2");

    // R3/R4 compares
    step(1, 0, 0, 8'h05, 0, 8'h05, 0, 0, "R3");   // equal: Z
    step(1, 0, 0, 8'h01, 0, 8'h02, 0, 0, "R4");   // borrow, negative
    step(1, 1, 0, 0, 8'h80, 8'h01, 0, 0, "R4");   // overflow
    step(1, 1, 0, 0, 8'h7F, 8'hFF, 0, 0, "R4");   // overflow other way
    step(1, 2, 0, 8'h30, 8'h10, 8'h00, 0, 0, "R3");
    step(1, 2, 0, 8'h00, 8'h00, 8'h77, 0, 0, "R3");

    // R5 bit tests, C kept
    step(1, 0, 0, 8'h00, 0, 8'h01, 0, 0, "R4");   // C=1
    step(1, 3, 0, 8'hF0, 0, 8'h80, 0, 0, "R5");
    step(1, 4, 0, 0, 8'h0F, 8'hF0, 0, 0, "R5");
    step(1, 1, 0, 0, 8'h80, 8'h01, 0, 0, "R4");   // V=1
    step(1, 3, 0, 8'h01, 0, 8'h03, 0, 0, "R5");   // V cleared

    // R6 clear
    step(1, 0, 0, 8'h00, 0, 8'h81, 0, 0, "R4");
    step(1, 5, 0, 0, 0, 0, 0, 0, "R6");

    // R7 flag clears
    step(1, 1, 0, 0, 8'h80, 8'h01, 0, 0, "R4");   // V=1 C=0
    step(1, 0, 0, 8'h80, 0, 8'h7F, 0, 0, "R4");   // V=1 N=0
    step(1, 0, 0, 8'h01, 0, 8'h80, 0, 0, "R4");   // N,V,C set
    step(1, 6, 0, 0, 0, 0, 0, 0, "R7");
    step(1, 8, 0, 0, 0, 0, 0, 0, "R7");
    step(1, 7, 0, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R2");

    // R8/R9/R10 all codes under four flag states
    for (int s = 0; s < 4; s++) begin
      for (int code = 0; code < 16; code++) begin
        case (s)
          0: step(1, 0, 0, 8'h05, 0, 8'h05, 0, 0, "R3");
          1: step(1, 0, 0, 8'h01, 0, 8'h02, 0, 0, "R3");
          2: step(1, 0, 0, 8'h80, 0, 8'h01, 0, 0, "R3");
          default: step(1, 0, 0, 8'h02, 0, 8'h01, 0, 0, "R3");
        endcase
        step(1, 9, code, 0, 0, 0, 8'h10 + code, 16'h1000 + code * 3, "R10");
      end
    end

    // R9 wraparound corners
    step(1, 9, 0, 0, 0, 0, 8'h7F, 16'hFFFF, "R9");
    step(1, 9, 0, 0, 0, 0, 8'h80, 16'h0005, "R9");
    step(1, 9, 1, 0, 0, 0, 8'h80, 16'hFFFE, "R9");
    step(1, 6, 0, 0, 0, 0, 0, 0, "R11");           // clears br_taken
    step(0, 9, 0, 0, 0, 0, 8'h40, 16'h2000, "R2"); // unstrobed branch

    // randomized mix
    for (int k = 0; k < 1500; k++) begin
      step(($urandom_range(0, 3) != 0), $urandom_range(0, 15), $urandom_range(0, 15),
           $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 255),
           $urandom_range(0, 255), $urandom_range(0, 65535), "R3");
    end

    // R1 reset after activity
    step(1, 7, 0, 0, 0, 0, 0, 0, "R7");
    do_reset();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule